// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose I/O with sixteen pins, reached through a small 16-bit register bus. Software sets output values and pin directions. It reads back the synchronized pin levels. It also arranges for any pin to raise an interrupt. Every configuration register carries one bit per pin, with bit i belonging to pin i.

Each pin's trigger is chosen from three independent registers:
- A trigger-kind bit selects edge or level detection.
- An edge-polarity bit selects a rising or a falling edge.
- A level-polarity bit selects active-high or active-low.

A per-pin mask bit blocks detection when it is 1. Detected events set bits in a sticky status register, and one summary line reports any pending unmasked event. The bank has no both-edge mode. Software gets the same effect by rewriting the edge polarity after each event, and that rewrite leaves all other configuration untouched. Three further registers (sleep value, battery-fault value and alternate-function select) are plain read/write storage.

Bus access: a write takes effect at the rising clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and zero otherwise.

Address map (4-bit word address):

| Address | Register | Access |
|---|---|---|
| 0 | output data | read/write |
| 1 | direction (1 = drive) | read/write |
| 2 | pin level | read-only |
| 3 | trigger kind | read/write |
| 4 | edge polarity | read/write |
| 5 | level polarity | read/write |
| 6 | mask | read/write |
| 7 | interrupt status | read, write-to-clear |
| 8 | sleep value | read/write |
| 9 | fault value | read/write |
| 10 | alternate-function select | read/write |
| other | — | read as zero |

Top module: `gpio_bank`

## Requirements
- R1: Writing address 0 sets `pins_out` and writing address 1 sets `pins_oe` (1 = pin driven). Both read back unchanged at their own addresses, and `pins_oe` only changes on a write to address 1.
- R2: Reading address 2 returns the synchronized level of every input pin. A write to address 2 has no effect.
- R3: With trigger-kind bit 1 and edge-polarity bit 1, a rising edge on that pin sets its status bit. A falling edge does not set it.
- R4: With trigger-kind bit 1 and edge-polarity bit 0, a falling edge sets the status bit. A rising edge does not set it.
- R5: With trigger-kind bit 0, the status bit is set on every cycle the pin is high (level-polarity bit 1) or low (level-polarity bit 0).
- R6: A mask bit of 1 prevents that pin from setting its status bit.
- R7: `irq` is high exactly when some status bit is set whose mask bit is 0. Setting every mask bit forces `irq` low without changing the status register.
- R8: Status bits are sticky. A write to address 7 keeps only the status bits where the written data is 1, so writing zero clears them all.
- R9: An event detected in the same cycle as a clearing write to address 7 leaves its status bit set.
- R10: Rewriting the edge-polarity register changes the detected edge on the next transition. The trigger-kind, level-polarity and mask registers are unaffected, so alternating polarity catches both edges.
- R11: Addresses 8, 9 and 10 are storage that read back what was written. Writing them changes no other register and no output.
- R12: After reset, mask is all ones, direction and output are all zero, status is zero and `irq` is low.
- R13: A pin change is visible at address 2 after two rising clock edges, and in the status register after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable (with bus_sel) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| pins_in | input | 16 | Raw asynchronous pin inputs |
| pins_out | output | 16 | Output data to pad drivers |
| pins_oe | output | 16 | Per-pin drive enable |
| irq | output | 1 | Bank summary interrupt |

## Verification
Each fault in the internal state shows up at the ports within a few cycles:
- A corrupted configuration bit (trigger kind, polarity or mask) changes whether a status bit rises three clocks after a pin transition. The bench reads back that status bit and `irq` on the following cycle.
- A broken delayed copy in the edge detector makes events fire on the wrong transition, or fire repeatedly on a steady level. This is caught by the per-pin rising and falling sweeps.
- A status register that drops bits without a write, or loses an event to a clearing write, is visible at the next read of address 7.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DOUT  = 4'd0,
        RA_DIR   = 4'd1,
        RA_PIN   = 4'd2,
        RA_KIND  = 4'd3,
        RA_EDGE  = 4'd4,
        RA_LEVEL = 4'd5,
        RA_MASK  = 4'd6,
        RA_STAT  = 4'd7,
        RA_SLEEP = 4'd8,
        RA_FAULT = 4'd9,
        RA_ALT   = 4'd10
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign synced = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] samp,
    input  logic [W-1:0] kind_edge,
    input  logic [W-1:0] edge_rise,
    input  logic [W-1:0] lvl_high,
    input  logic [W-1:0] blocked,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rose, fell, edge_hit, lvl_hit;
        assign rose     = samp[i] & ~prev_q[i];
        assign fell     = ~samp[i] & prev_q[i];
        assign edge_hit = edge_rise[i] ? rose : fell;
        assign lvl_hit  = lvl_high[i] ? samp[i] : ~samp[i];
        assign hit[i]   = ~blocked[i] & (kind_edge[i] ? edge_hit : lvl_hit);
    end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W       = 16,
    parameter int STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pins_in,
    output logic [W-1:0]      pins_out,
    output logic [W-1:0]      pins_oe,
    output logic              irq
);
    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] dir;
        logic [W-1:0] kind;
        logic [W-1:0] edgep;
        logic [W-1:0] lvl;
        logic [W-1:0] mask;
        logic [W-1:0] stat;
        logic [W-1:0] sleep;
        logic [W-1:0] fault;
        logic [W-1:0] alt;
    } bank_regs_t;

    bank_regs_t   r_d, r_q;
    logic [W-1:0] pin_now;
    logic [W-1:0] ev_hit;
    logic         wr_en;
    logic [W-1:0] stat_vis, mask_vis;

    gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pins_in),
        .synced (pin_now)
    );

    gpio_trig_detect #(.W(W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp      (pin_now),
        .kind_edge (r_q.kind),
        .edge_rise (r_q.edgep),
        .lvl_high  (r_q.lvl),
        .blocked   (r_q.mask),
        .hit       (ev_hit)
    );

    assign wr_en = bus_sel & bus_we;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (bus_addr)
                RA_DOUT:  r_d.dout  = bus_wdata;
                RA_DIR:   r_d.dir   = bus_wdata;
                RA_KIND:  r_d.kind  = bus_wdata;
                RA_EDGE:  r_d.edgep = bus_wdata;
                RA_LEVEL: r_d.lvl   = bus_wdata;
                RA_MASK:  r_d.mask  = bus_wdata;
                RA_STAT:  r_d.stat  = r_q.stat & bus_wdata;
                RA_SLEEP: r_d.sleep = bus_wdata;
                RA_FAULT: r_d.fault = bus_wdata;
                RA_ALT:   r_d.alt   = bus_wdata;
                default:  ;
            endcase
        end
        // a fresh event always overrides a clearing write
        r_d.stat = r_d.stat | ev_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                RA_DOUT:  bus_rdata = r_q.dout;
                RA_DIR:   bus_rdata = r_q.dir;
                RA_PIN:   bus_rdata = pin_now;
                RA_KIND:  bus_rdata = r_q.kind;
                RA_EDGE:  bus_rdata = r_q.edgep;
                RA_LEVEL: bus_rdata = r_q.lvl;
                RA_MASK:  bus_rdata = r_q.mask;
                RA_STAT:  bus_rdata = r_q.stat;
                RA_SLEEP: bus_rdata = r_q.sleep;
                RA_FAULT: bus_rdata = r_q.fault;
                RA_ALT:   bus_rdata = r_q.alt;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pins_out = r_q.dout;
    assign pins_oe  = r_q.dir;
    assign irq      = |(r_q.stat & ~r_q.mask);
    assign stat_vis = r_q.stat;
    assign mask_vis = r_q.mask;
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
    import gpio_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pins_oe,
    input logic              irq,
    input logic [W-1:0]      stat_q,
    input logic [W-1:0]      mask_q
);
    logic dir_wr, stat_wr;
    assign dir_wr  = bus_sel && bus_we && (bus_addr == RA_DIR);
    assign stat_wr = bus_sel && bus_we && (bus_addr == RA_STAT);

    // R1
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr |=> $stable(pins_oe));

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6
    masked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata == '0) |=> ((stat_q & $past(mask_q)) == '0));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pins_oe   (pins_oe),
    .irq       (irq),
    .stat_q    (stat_vis),
    .mask_q    (mask_vis)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, pins_out, pins_oe;
    logic [15:0] pins = '0;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    logic [15:0] rv, tmp;

    localparam logic [3:0] A_DOUT = 4'd0, A_DIR = 4'd1, A_PIN = 4'd2,
        A_KIND = 4'd3, A_EDGE = 4'd4, A_LVL = 4'd5, A_MASK = 4'd6,
        A_STAT = 4'd7, A_SLP = 4'd8, A_FLT = 4'd9, A_ALT = 4'd10;

    always #2.5 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(1);
        // R12 reset state
        bread(A_MASK, rv); check("R12 mask", rv, 16'hFFFF);
        bread(A_DIR, rv);  check("R12 dir", rv, 16'h0000);
        bread(A_STAT, rv); check("R12 stat", rv, 16'h0000);
        check("R12 oe", pins_oe, 16'h0000);
        check("R12 out", pins_out, 16'h0000);
        check("R12 irq", {15'd0, irq}, 16'h0000);

        // R1 output and direction registers
        for (int k = 0; k < 16; k++) begin
            tmp = 16'h1 << k;
            bwrite(A_DOUT, tmp ^ 16'h5A5A);
            bwrite(A_DIR, ~tmp);
            check("R1 out port", pins_out, tmp ^ 16'h5A5A);
            check("R1 oe port", pins_oe, ~tmp);
            bread(A_DOUT, rv); check("R1 out read", rv, tmp ^ 16'h5A5A);
            bread(A_DIR, rv);  check("R1 dir read", rv, ~tmp);
        end

        // R2 pin readback, write to pin address ignored
        for (int k = 0; k < 16; k++) begin
            pins = (16'h1 << k) | 16'h8001;
            waitc(2);
            bread(A_PIN, rv); check("R2 pin read", rv, (16'h1 << k) | 16'h8001);
        end
        bwrite(A_PIN, 16'h0000);
        bread(A_PIN, rv); check("R2 pin write ignored", rv, pins);
        bread(A_DOUT, rv); check("R2 dout untouched", rv, 16'h8000 ^ 16'h5A5A);

        // R3 rising edges
        bwrite(A_KIND, 16'hFFFF); bwrite(A_EDGE, 16'hFFFF); bwrite(A_MASK, 16'h0000);
        for (int k = 0; k < 16; k++) begin
            pins = 16'h0; waitc(4); bwrite(A_STAT, 16'h0);
            pins = 16'h1 << k; waitc(3);
            bread(A_STAT, rv); check("R3 rise sets", rv, 16'h1 << k);
            check("R7 irq on rise", {15'd0, irq}, 16'h1);
            bwrite(A_STAT, 16'h0);
            pins = 16'h0; waitc(3);
            bread(A_STAT, rv); check("R3 fall ignored", rv, 16'h0);
        end

        // R4 falling edges
        bwrite(A_EDGE, 16'h0000);
        for (int k = 0; k < 16; k++) begin
            pins = 16'hFFFF; waitc(4); bwrite(A_STAT, 16'h0);
            pins = ~(16'h1 << k); waitc(3);
            bread(A_STAT, rv); check("R4 fall sets", rv, 16'h1 << k);
            bwrite(A_STAT, 16'h0);
            pins = 16'hFFFF; waitc(3);
            bread(A_STAT, rv); check("R4 rise ignored", rv, 16'h0);
        end

        // R5 levels
        bwrite(A_KIND, 16'h0000);
        for (int k = 0; k < 16; k++) begin
            tmp = (16'h1 << k) ^ 16'h0F0F;
            bwrite(A_LVL, 16'hFFFF);
            pins = tmp; waitc(3); bwrite(A_STAT, 16'h0); waitc(1);
            bread(A_STAT, rv); check("R5 high level", rv, tmp);
            bwrite(A_LVL, 16'h0000); waitc(1); bwrite(A_STAT, 16'h0); waitc(1);
            bread(A_STAT, rv); check("R5 low level", rv, ~tmp);
        end

        // R6 masking, R7 summary
        bwrite(A_LVL, 16'hFFFF); pins = 16'hFFFF;
        for (int k = 0; k < 16; k++) begin
            tmp = (16'h1 << k) | 16'hC003;
            bwrite(A_MASK, tmp); waitc(3); bwrite(A_STAT, 16'h0); waitc(2);
            bread(A_STAT, rv); check("R6 masked bits clear", rv, ~tmp);
            bwrite(A_MASK, 16'hFFFF);
            check("R7 irq low all masked", {15'd0, irq}, 16'h0);
            bread(A_STAT, rv); check("R7 stat unchanged", rv, ~tmp);
            bwrite(A_STAT, 16'h0);
        end
        bwrite(A_MASK, 16'hFFFF); bwrite(A_STAT, 16'h0); waitc(1);
        bwrite(A_MASK, 16'hFFFE);
        check("R7 irq low no status", {15'd0, irq}, 16'h0);

        // R8 sticky and partial clear
        bwrite(A_KIND, 16'hFFFF); bwrite(A_EDGE, 16'hFFFF); bwrite(A_MASK, 16'h0);
        pins = 16'h0; waitc(4); bwrite(A_STAT, 16'h0);
        pins = 16'hFFFF; waitc(3); waitc(5);
        bread(A_STAT, rv); check("R8 sticky", rv, 16'hFFFF);
        bwrite(A_STAT, 16'hA5A5);
        bread(A_STAT, rv); check("R8 partial clear", rv, 16'hA5A5);
        bwrite(A_STAT, 16'h0);
        bread(A_STAT, rv); check("R8 zero clears", rv, 16'h0);
        check("R8 irq after clear", {15'd0, irq}, 16'h0);

        // R9 event beats clear
        bwrite(A_KIND, 16'h0000); bwrite(A_LVL, 16'hFFFF);
        pins = 16'h0008; waitc(3);
        bwrite(A_STAT, 16'h0);
        bread(A_STAT, rv); check("R9 event wins", rv, 16'h0008);

        // R10 both-edge emulation via polarity rewrite
        bwrite(A_KIND, 16'hFFFF); bwrite(A_EDGE, 16'hFFFF); bwrite(A_LVL, 16'h3C3C);
        pins = 16'h0; waitc(4); bwrite(A_STAT, 16'h0);
        pins = 16'h0020; waitc(3);
        bread(A_STAT, rv); check("R10 first edge", rv, 16'h0020);
        bread(A_EDGE, rv); bwrite(A_EDGE, rv & ~16'h0020);
        bwrite(A_STAT, 16'h0);
        bread(A_KIND, rv); check("R10 kind kept", rv, 16'hFFFF);
        bread(A_LVL, rv);  check("R10 level kept", rv, 16'h3C3C);
        bread(A_MASK, rv); check("R10 mask kept", rv, 16'h0000);
        pins = 16'h0; waitc(3);
        bread(A_STAT, rv); check("R10 second edge", rv, 16'h0020);

        // R11 storage registers
        bwrite(A_DOUT, 16'h1111); bwrite(A_DIR, 16'h2222);
        bwrite(A_SLP, 16'h1234); bwrite(A_FLT, 16'hABCD); bwrite(A_ALT, 16'h0F0F);
        bread(A_SLP, rv); check("R11 sleep", rv, 16'h1234);
        bread(A_FLT, rv); check("R11 fault", rv, 16'hABCD);
        bread(A_ALT, rv); check("R11 alt", rv, 16'h0F0F);
        check("R11 out kept", pins_out, 16'h1111);
        check("R11 oe kept", pins_oe, 16'h2222);
        bread(A_EDGE, rv); check("R11 edge kept", rv, 16'hFFDF);

        // R13 synchronizer latency
        bwrite(A_KIND, 16'h0000); bwrite(A_LVL, 16'hFFFF);
        pins = 16'h0; waitc(4); bwrite(A_STAT, 16'h0);
        pins = 16'h0100; waitc(1);
        bread(A_PIN, rv); check("R13 pin not yet", rv, 16'h0000);
        waitc(1);
        bread(A_PIN, rv); check("R13 pin after two", rv, 16'h0100);
        bread(A_STAT, rv); check("R13 stat not yet", rv, 16'h0000);
        waitc(1);
        bread(A_STAT, rv); check("R13 stat after three", rv, 16'h0100);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule